// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address for 4 KB pages. It reads one 32-bit descriptor from a flat table in memory. The table's location comes from a table base register, which is written through a one-cycle write strobe. A requester offers a virtual address, an access kind (read, write or execute) and an access size. The walker then does the following:

- It checks the address alignment.
- It issues a single descriptor read on a simple request/response memory port.
- It checks the descriptor's valid bit and permission bits.
- It reports the outcome on a one-cycle completion pulse. The outcome is either the physical address with its cacheable attribute, or a fault reason code.

The upper 20 address bits index the table directly, with one descriptor per page. The descriptor's upper 20 bits give the physical page number, and the low 12 address bits pass through unchanged as the page offset.

The descriptor fields are:

| Bit(s) | Meaning |
|---|---|
| 0 | valid |
| 1 | read allowed |
| 2 | write allowed |
| 3 | execute allowed |
| 4 | cacheable |
| 31:12 | physical page number |

The walker holds one walk at a time. It takes a new request only when it is idle.

Top module: `ptw_top`

## Requirements
- R1: While reset is held, and right after it is released, `done_o` and `mem_req_valid` are low and `req_ready` is high. The table base resets to zero.
- R2: `req_ready` is high only when the walker is idle. While a walk is in progress it stays low, and no new request is taken.
- R3: For an aligned request, the cycle after acceptance raises `mem_req_valid` with `mem_req_addr` = base + 4 × vaddr[31:12]. The addition wraps at 32 bits.
- R4: `mem_req_valid` and `mem_req_addr` stay steady until a cycle in which `mem_req_ready` is high. The walker then drops the request and waits for the response.
- R5: A valid descriptor whose permission allows the access completes with `done_fault` = 0. `done_paddr` = {descriptor[31:12], vaddr[11:0]} and `done_cacheable` = descriptor bit 4.
- R6: A descriptor with bit 0 clear completes with `done_fault` = 2 (translation fault), whatever its permission bits. `done_paddr` and `done_cacheable` are then zero.
- R7: On a valid descriptor, the permission checks are:
  - kind 0 (read) needs bit 1.
  - kind 1 (write) needs bit 2.
  - kind 2 (execute) needs bit 3.
  - kind 3 is never permitted.

  A failed check completes with `done_fault` = 1 and a zero address and cacheable flag.
- R8: Size 0 is a byte and is always aligned. Size 1 is a halfword and needs vaddr[0] = 0. Sizes 2 and 3 are a word and need vaddr[1:0] = 0. A misaligned request issues no memory read. It completes in the cycle after acceptance with `done_fault` = 3 and a zero address and cacheable flag.
- R9: `done_o` rises in the cycle after the response is taken and lasts exactly one cycle. The walker is idle again in the following cycle.
- R10: A table base write changes the base from the next cycle on. A request accepted in the same cycle as a base write uses the previous base. A later request uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | 32 | New table base value |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address, zero on fault |
| done_cacheable | output | 1 | Cacheable attribute, zero on fault |
| done_fault | output | 2 | 0 none, 1 permission, 2 translation, 3 alignment |

## Verification
A table base write and the acceptance of a new request can fall in the same cycle. The walker must then build the descriptor address from the old base, and only later requests may see the new one. The bench drives the base strobe and `req_valid` together at one edge. It checks the observed `mem_req_addr` against the old base, then issues a follow-up request and expects the new base. Random vectors repeat this pairing at random points, alongside stalled memory handshakes and response latencies of zero to three cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_PERM  = 2'd1,
    FLT_XLAT  = 2'd2,
    FLT_ALIGN = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_WAIT  = 2'd2,
    W_DONE  = 2'd3
  } wstate_e;

  // descriptor bit positions
  localparam int unsigned DB_VALID = 0;
  localparam int unsigned DB_RD    = 1;
  localparam int unsigned DB_WR    = 2;
  localparam int unsigned DB_EX    = 3;
  localparam int unsigned DB_CACHE = 4;

  // size 0 byte, 1 halfword, 2/3 word
  function automatic logic addr_misaligned(input logic [1:0] a_lo, input logic [1:0] sz);
    logic r;
    case (sz)
      2'd0:    r = 1'b0;
      2'd1:    r = a_lo[0];
      default: r = (a_lo != 2'b00);
    endcase
    return r;
  endfunction

  // rwx = {exec, write, read}
  function automatic logic perm_granted(input logic [2:0] rwx, input acc_e kind);
    logic r;
    case (kind)
      ACC_RD:  r = rwx[0];
      ACC_WR:  r = rwx[1];
      ACC_EX:  r = rwx[2];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= RST_VAL;
    else if (wr_en) base_q <= wr_data;
  end
endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PG_OFS = 12
) (
  input  logic [VA_W-1:0] desc,
  input  logic [VA_W-1:0] vaddr,
  input  acc_e            kind,
  output fault_e          fault,
  output logic [VA_W-1:0] paddr,
  output logic            cacheable
);
  always_comb begin
    fault = FLT_NONE;
    if (!desc[DB_VALID])
      fault = FLT_XLAT;
    else if (!perm_granted(desc[DB_EX:DB_RD], kind))
      fault = FLT_PERM;
  end

  always_comb begin
    if (fault == FLT_NONE) begin
      paddr     = {desc[VA_W-1:PG_OFS], vaddr[PG_OFS-1:0]};
      cacheable = desc[DB_CACHE];
    end else begin
      paddr     = '0;
      cacheable = 1'b0;
    end
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  logic    misalign,
  input  logic    issue_ok,
  input  logic    rsp_valid,
  output wstate_e state
);
  wstate_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      W_IDLE:  if (accept) nxt = misalign ? W_DONE : W_FETCH;
      W_FETCH: if (issue_ok) nxt = W_WAIT;
      W_WAIT:  if (rsp_valid) nxt = W_DONE;
      default: nxt = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= W_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned   VA_W        = 32,
  parameter int unsigned   PG_OFS      = 12,
  parameter int unsigned   ENTRY_BYTES = 4,
  parameter logic [31:0]   BASE_RST    = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_wr_en,
  input  logic [VA_W-1:0] base_wr_data,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  input  logic [1:0]      req_size,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            done_o,
  output logic [VA_W-1:0] done_paddr,
  output logic            done_cacheable,
  output logic [1:0]      done_fault
);
  localparam int unsigned IDX_W = VA_W - PG_OFS;
  localparam int unsigned ESH   = $clog2(ENTRY_BYTES);

  function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    logic [VA_W-1:0] off;
    off = VA_W'(idx) << ESH;
    return base + off;
  endfunction

  logic [VA_W-1:0] base_q;
  wstate_e         state;

  // named internal events
  logic evt_accept, evt_misalign, evt_issue, evt_rsp, in_wait;

  logic [VA_W-1:0] vaddr_q, daddr_q, res_paddr_q;
  acc_e            kind_q;
  fault_e          res_fault_q;
  logic            res_cache_q;

  fault_e          ev_fault;
  logic [VA_W-1:0] ev_paddr;
  logic            ev_cache;

  assign req_ready     = (state == W_IDLE);
  assign in_wait       = (state == W_WAIT);
  assign mem_req_valid = (state == W_FETCH);
  assign mem_req_addr  = daddr_q;

  assign evt_accept   = req_valid && req_ready;
  assign evt_misalign = addr_misaligned(req_vaddr[1:0], req_size);
  assign evt_issue    = mem_req_valid && mem_req_ready;
  assign evt_rsp      = in_wait && mem_rsp_valid;

  ptw_base_reg #(.AW(VA_W), .RST_VAL(BASE_RST[VA_W-1:0])) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .base_q  (base_q)
  );

  ptw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (evt_accept),
    .misalign  (evt_misalign),
    .issue_ok  (evt_issue),
    .rsp_valid (mem_rsp_valid),
    .state     (state)
  );

  ptw_desc_eval #(.VA_W(VA_W), .PG_OFS(PG_OFS)) u_eval (
    .desc      (mem_rsp_data),
    .vaddr     (vaddr_q),
    .kind      (kind_q),
    .fault     (ev_fault),
    .paddr     (ev_paddr),
    .cacheable (ev_cache)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      daddr_q <= '0;
      kind_q  <= ACC_RD;
    end else if (evt_accept) begin
      vaddr_q <= req_vaddr;
      kind_q  <= acc_e'(req_kind);
      daddr_q <= entry_addr(base_q, req_vaddr[VA_W-1:PG_OFS]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fault_q <= FLT_NONE;
      res_paddr_q <= '0;
      res_cache_q <= 1'b0;
    end else if (evt_accept && evt_misalign) begin
      res_fault_q <= FLT_ALIGN;
      res_paddr_q <= '0;
      res_cache_q <= 1'b0;
    end else if (evt_rsp) begin
      res_fault_q <= ev_fault;
      res_paddr_q <= ev_paddr;
      res_cache_q <= ev_cache;
    end
  end

  assign done_o         = (state == W_DONE);
  assign done_paddr     = res_paddr_q;
  assign done_cacheable = res_cache_q;
  assign done_fault     = res_fault_q;
endmodule

// File: rtl/ptw_sva.sv
module ptw_sva #(
  parameter int unsigned VA_W        = 32,
  parameter int unsigned PG_OFS      = 12,
  parameter int unsigned ENTRY_BYTES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_size,
  input logic [VA_W-1:0] base_q,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic [VA_W-1:0] mem_rsp_data,
  input logic            in_wait,
  input logic            done_o,
  input logic [VA_W-1:0] done_paddr,
  input logic            done_cacheable,
  input logic [1:0]      done_fault
);
  localparam int unsigned ESH = $clog2(ENTRY_BYTES);

  logic take, odd;
  logic [VA_W-1:0] va_seen;
  assign take = req_valid && req_ready;
  assign odd  = ((req_size == 2'd1) && req_vaddr[0]) || (req_size[1] && (req_vaddr[1:0] != 2'b00));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    va_seen <= '0;
    else if (take) va_seen <= req_vaddr;
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !done_o && !in_wait));

  a_r3_desc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !odd) |=> (mem_req_valid &&
      mem_req_addr == $past(base_q) + ((VA_W'($past(req_vaddr) >> PG_OFS)) << ESH)));

  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_fault == 2'd0) |-> (done_paddr[PG_OFS-1:0] == va_seen[PG_OFS-1:0]));

  a_r6_invalid_desc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && mem_rsp_valid && !mem_rsp_data[0]) |=> (done_o && done_fault == 2'd2));

  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_fault != 2'd0) |-> (done_paddr == '0 && !done_cacheable));

  a_r8_align_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (take && odd) |=> (done_o && done_fault == 2'd3 && !mem_req_valid));

  a_r9_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && mem_rsp_valid) |=> done_o);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && req_ready));
endmodule

bind ptw_top ptw_sva #(.VA_W(VA_W), .PG_OFS(PG_OFS), .ENTRY_BYTES(ENTRY_BYTES)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .req_size       (req_size),
  .base_q         (base_q),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_valid  (mem_rsp_valid),
  .mem_rsp_data   (mem_rsp_data),
  .in_wait        (in_wait),
  .done_o         (done_o),
  .done_paddr     (done_paddr),
  .done_cacheable (done_cacheable),
  .done_fault     (done_fault)
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_o;
  logic [31:0] done_paddr;
  logic        done_cacheable;
  logic [1:0]  done_fault;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] base_m = 32'h0;

  always #2.5 clk = ~clk;

  ptw_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_size(req_size),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_o(done_o), .done_paddr(done_paddr), .done_cacheable(done_cacheable),
    .done_fault(done_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit tb_odd(input logic [31:0] va, input logic [1:0] sz);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return va[0];
    return va[1] | va[0];
  endfunction

  function automatic logic [1:0] tb_fault(input logic [31:0] va, input logic [1:0] kind,
                                          input logic [1:0] sz, input logic [31:0] d);
    bit ok;
    if (tb_odd(va, sz)) return 2'd3;
    if (d[0] == 1'b0) return 2'd2;
    ok = (kind == 2'd0) ? d[1] : (kind == 2'd1) ? d[2] : (kind == 2'd2) ? d[3] : 1'b0;
    return ok ? 2'd0 : 2'd1;
  endfunction

  task automatic wr_base(input logic [31:0] b);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    base_m = b;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] sz,
                       input logic [31:0] d, input int stall, input int lat,
                       input bit wb, input logic [31:0] nb);
    logic [1:0]  ef;
    logic [31:0] ea, ep;
    logic        ec;
    ef = tb_fault(va, kind, sz, d);
    ea = base_m + {10'd0, va[31:12], 2'b00};
    ep = (ef == 2'd0) ? {d[31:12], va[11:0]} : 32'h0;
    ec = (ef == 2'd0) ? d[4] : 1'b0;
    chk(req_ready == 1'b1, "R2 idle ready", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_size = sz;
    base_wr_en = wb; base_wr_data = nb;
    @(negedge clk);
    req_valid = 1'b0; base_wr_en = 1'b0;
    if (wb) base_m = nb;
    if (ef == 2'd3) begin
      chk(done_o && !mem_req_valid, "R8 align no read", {done_o, mem_req_valid}, 2'b10);
      chk(done_fault == 2'd3, "R8 align code", done_fault, 3);
      chk(done_paddr == 0 && !done_cacheable, "R8 align zero", done_paddr, 0);
    end else begin
      chk(!req_ready, "R2 busy not ready", req_ready, 0);
      chk(mem_req_valid && mem_req_addr == ea, "R3 desc addr", mem_req_addr, ea);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea, "R4 hold req", mem_req_addr, ea);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(!mem_req_valid, "R4 req dropped", mem_req_valid, 0);
      for (int i = 0; i < lat; i++) begin
        chk(!done_o && !req_ready, "R9 wait resp", {done_o, req_ready}, 0);
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = d;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
      chk(done_o == 1'b1, "R9 done after resp", done_o, 1);
      if (ef == 2'd0) chk(done_fault == 0, "R5 no fault", done_fault, 0);
      else if (ef == 2'd2) chk(done_fault == 2, "R6 xlat fault", done_fault, 2);
      else chk(done_fault == 1, "R7 perm fault", done_fault, 1);
      chk(done_paddr == ep, "R5 paddr", done_paddr, ep);
      chk(done_cacheable == ec, "R5 cacheable", done_cacheable, ec);
    end
    @(negedge clk);
    chk(!done_o && req_ready, "R9 single pulse", {done_o, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    chk(!done_o && !mem_req_valid && req_ready, "R1 in reset", {done_o, mem_req_valid, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !mem_req_valid && req_ready, "R1 after reset", {done_o, mem_req_valid, req_ready}, 3'b001);
    // R1 base resets to zero: address is 4*index
    xlate(32'h0000_5000, 2'd0, 2'd2, 32'hABCDE_01F, 0, 0, 1'b0, 0);
    // R5 read/write/exec granted
    wr_base(32'h1000_0000);
    xlate(32'h1234_5678, 2'd0, 2'd2, 32'h87654_013, 1, 2, 1'b0, 0);
    xlate(32'hFFFF_F002, 2'd1, 2'd1, 32'h00001_005, 0, 0, 1'b0, 0);
    xlate(32'h0000_0FFF, 2'd2, 2'd0, 32'hFFFFF_009, 3, 1, 1'b0, 0);
    // R6 invalid with all permissions set
    xlate(32'h0040_0000, 2'd0, 2'd2, 32'h12345_01E, 0, 3, 1'b0, 0);
    // R7 each missing permission and reserved kind
    xlate(32'h0040_1000, 2'd0, 2'd2, 32'h12345_01D, 0, 0, 1'b0, 0);
    xlate(32'h0040_2000, 2'd1, 2'd2, 32'h12345_01B, 0, 0, 1'b0, 0);
    xlate(32'h0040_3000, 2'd2, 2'd2, 32'h12345_017, 0, 0, 1'b0, 0);
    xlate(32'h0040_4000, 2'd3, 2'd2, 32'h12345_01F, 0, 0, 1'b0, 0);
    // R8 misalignment variants
    xlate(32'h0000_1001, 2'd0, 2'd1, 32'h0, 0, 0, 1'b0, 0);
    xlate(32'h0000_1002, 2'd0, 2'd2, 32'h0, 0, 0, 1'b0, 0);
    xlate(32'h0000_1001, 2'd0, 2'd3, 32'h0, 0, 0, 1'b0, 0);
    // R3 wraparound of base + offset
    wr_base(32'hFFFF_FFF0);
    xlate(32'h0000_8000, 2'd0, 2'd2, 32'hCAFEB_003, 0, 0, 1'b0, 0);
    // R10 base write same cycle as acceptance, then later request
    xlate(32'h0001_2000, 2'd0, 2'd2, 32'h11111_003, 0, 1, 1'b1, 32'h2000_0000);
    xlate(32'h0001_2000, 2'd0, 2'd2, 32'h22222_013, 0, 1, 1'b0, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va, d;
      va = $urandom;
      if ($urandom_range(0, 3) != 0) va[1:0] = 2'b00;
      d = $urandom;
      if ($urandom_range(0, 4) != 0) d[0] = 1'b1;
      xlate(va, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), d,
            $urandom_range(0, 3), $urandom_range(0, 3),
            ($urandom_range(0, 5) == 0), $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule